// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block hands received frames to software through a ring of descriptors held in an external descriptor memory. A MAC front end marks the start of each frame and, at its end, reports the byte count (trailing 4-byte FCS included) and two error indications. For each frame the engine reads the descriptor at the current ring position. If that descriptor is still owned by hardware, the engine waits for the end of the frame. It then writes back length and status in a single memory write, hands the descriptor to software by clearing its ownership flag, and steps to the next ring entry.

When the current descriptor is still owned by software, the engine raises a sticky busy event, discards the frame and halts. It touches no memory until software issues an explicit resume. The ring position does not move during this, so the same descriptor is tried again after resume. A stop request lets a frame in progress finish, parks the engine and raises a stop-done event. Software re-arms descriptors by writing the memory directly.

Descriptor word (32 bits): bit 31 OWN_HW (1 means hardware owns the entry), bit 29 LAST (last entry of the ring), bits 19:16 error field, bits 15:0 length. All other bits are left as software wrote them. Error field bits: bit 16 FCS error reported by the MAC, bit 17 other MAC fault, bit 18 runt (length below `cfg_min_len`), bit 19 oversize (length above `cfg_max_len`). A frame is good when the whole field is zero.

States: S_IDLE (waiting), S_FETCH (descriptor read issued), S_CHECK (descriptor word returned), S_FILL (frame in progress into an owned descriptor), S_WBACK (single write-back), S_DROP (frame being discarded after a busy hit), S_HALT (halted until resume), S_STOP (parked on stop request).

Transitions:
- S_IDLE goes to S_STOP when a stop is requested. Otherwise it goes to S_FETCH on start of frame.
- S_FETCH always goes to S_CHECK.
- S_CHECK goes to S_FILL if OWN_HW is set, and to S_DROP if it is clear.
- S_FILL goes to S_WBACK once the end of frame has been seen.
- S_WBACK always goes to S_IDLE.
- S_DROP goes to S_HALT once the end of frame has been seen.
- S_HALT goes to S_IDLE once the halt flag is cleared.
- S_STOP goes to S_IDLE when the stop request drops.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset, `evt_busy`, `evt_stop_done`, `rx_halted`, `desc_rd_en` and `desc_wr_en` are 0, and `desc_addr` equals `cfg_ring_base`.
- R2: A frame that lands in a descriptor with OWN_HW (bit 31) set produces exactly one write to that descriptor's address. The write has bit 31 cleared, bits 15:0 equal to the reported length including FCS, and bits 19:16 holding the error field. Every other bit, including LAST (bit 29), keeps the value that was read.
- R3: The runt bit (18) is set when length < `cfg_min_len`, and the oversize bit (19) is set when length > `cfg_max_len`.
- R4: The MAC's FCS error and fault indications are copied to bits 16 and 17. With no error, bits 19:16 are zero.
- R5: After each write-back the ring position advances by one. After writing a descriptor with LAST (bit 29) set, it returns to `cfg_ring_base`.
- R6: When the fetched descriptor has bit 31 clear, `evt_busy` and `rx_halted` become 1, the frame is discarded and nothing is written.
- R7: While `rx_halted` is 1, frames are ignored and the descriptor memory is neither read nor written.
- R8: A pulse on `evt_busy_clr` clears `evt_busy` without releasing the halt. A pulse on `rx_resume` clears `rx_halted`, and reception continues at the same ring position that hit busy.
- R9: With `rx_stop_req` raised during a frame, that frame is completed and written back before `evt_stop_done` rises. While stopped, frames are ignored. `evt_stop_clr` clears the event, and dropping the request resumes reception.
- R10: An end of frame reported before the descriptor check completes (one cycle after start) is held and still produces a correct write-back.
- R11: The write-back occurs only after the end of frame, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ring_base | input | AW | Address of the first ring entry |
| cfg_min_len | input | 16 | Runt threshold |
| cfg_max_len | input | 16 | Oversize threshold |
| rx_sof | input | 1 | Start-of-frame pulse |
| rx_eof | input | 1 | End-of-frame pulse, qualifies length and errors |
| rx_len | input | 16 | Frame byte count including FCS |
| rx_fcs_err | input | 1 | FCS mismatch reported by the MAC |
| rx_mac_err | input | 1 | Other MAC fault |
| rx_stop_req | input | 1 | Stop request level |
| rx_resume | input | 1 | Clear-halt command pulse |
| evt_busy_clr | input | 1 | Write-one-to-clear for busy event |
| evt_stop_clr | input | 1 | Write-one-to-clear for stop-done event |
| desc_rd_en | output | 1 | Descriptor read strobe, data returned next cycle |
| desc_addr | output | AW | Descriptor address for read and write |
| desc_rd_data | input | 32 | Descriptor read data |
| desc_wr_en | output | 1 | Descriptor write strobe |
| desc_wr_data | output | 32 | Descriptor write data |
| evt_busy | output | 1 | Sticky busy event |
| evt_stop_done | output | 1 | Sticky stop-complete event |
| rx_halted | output | 1 | Reception halted |

## Verification
The hardest situation to reach is a busy hit partway around the ring, followed by a resume that must land on the same entry. The bench walks the ring fully once, re-arms only the first entry, and sends two more frames. The second of these meets a descriptor left owned by software. A frame is then sent while halted, and the busy event is cleared on its own before resume, to prove that the two controls are independent. A second hard case is an end of frame arriving while the descriptor read is still in flight. The bench produces it by sending the end pulse one cycle after the start.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
    localparam int DESC_W    = 32;
    localparam int OWN_BIT   = 31;
    localparam int LAST_BIT  = 29;
    localparam int ERR_LSB   = 16;
    localparam int ERR_W     = 4;
    localparam int LEN_LSB   = 0;
    localparam int LEN_W     = 16;
    localparam int E_FCS     = 0;
    localparam int E_MAC     = 1;
    localparam int E_RUNT    = 2;
    localparam int E_OVER    = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_FILL,
        S_WBACK,
        S_DROP,
        S_HALT,
        S_STOP
    } rdr_state_e;
endpackage

// File: rtl/rdr_fsm.sv
module rdr_fsm
    import rdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_sof,
    input  logic       rx_eof,
    input  logic       stop_req,
    input  logic       halt_q,
    input  logic       desc_owned,
    input  logic       eof_seen,
    output rdr_state_e state,
    output logic       rd_en,
    output logic       wr_en,
    output logic       advance,
    output logic       cap_desc,
    output logic       eof_cap_en,
    output logic       eof_clr,
    output logic       busy_set,
    output logic       stop_set
);
    rdr_state_e nxt;
    logic       take_frame;
    logic       frame_done;

    assign take_frame = rx_sof && !stop_req;
    assign frame_done = eof_seen || rx_eof;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (stop_req)        nxt = S_STOP;
                else if (rx_sof)     nxt = S_FETCH;
            end
            S_FETCH:                 nxt = S_CHECK;
            S_CHECK:                 nxt = desc_owned ? S_FILL : S_DROP;
            S_FILL:  if (frame_done) nxt = S_WBACK;
            S_WBACK:                 nxt = S_IDLE;
            S_DROP:  if (frame_done) nxt = S_HALT;
            S_HALT:  if (!halt_q)    nxt = S_IDLE;
            S_STOP:  if (!stop_req)  nxt = S_IDLE;
            default:                 nxt = S_IDLE;
        endcase
    end

    always_comb begin
        rd_en      = 1'b0;
        wr_en      = 1'b0;
        advance    = 1'b0;
        cap_desc   = 1'b0;
        eof_cap_en = 1'b0;
        eof_clr    = 1'b0;
        busy_set   = 1'b0;
        stop_set   = 1'b0;
        unique case (state)
            S_IDLE: begin
                stop_set   = stop_req;
                eof_cap_en = take_frame;
            end
            S_FETCH: begin
                rd_en      = 1'b1;
                eof_cap_en = 1'b1;
            end
            S_CHECK: begin
                cap_desc   = 1'b1;
                eof_cap_en = 1'b1;
                busy_set   = !desc_owned;
            end
            S_FILL:  eof_cap_en = 1'b1;
            S_WBACK: begin
                wr_en      = 1'b1;
                advance    = 1'b1;
                eof_clr    = 1'b1;
            end
            S_DROP:  eof_cap_en = 1'b1;
            S_HALT:  eof_clr    = 1'b1;
            S_STOP:  eof_clr    = 1'b1;
            default: eof_clr    = 1'b1;
        endcase
    end
endmodule

// File: rtl/rdr_ptr.sv
module rdr_ptr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base,
    input  logic          advance,
    input  logic          last_entry,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= '0;
        else if (advance)
            idx_q <= last_entry ? '0 : idx_q + 1'b1;
    end

    assign addr = base + idx_q;
endmodule

// File: rtl/rdr_wb.sv
module rdr_wb
    import rdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eof_cap_en,
    input  logic              eof_clr,
    input  logic              cap_desc,
    input  logic              rx_eof,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_fcs_err,
    input  logic              rx_mac_err,
    input  logic [LEN_W-1:0]  min_len,
    input  logic [LEN_W-1:0]  max_len,
    input  logic [DESC_W-1:0] rd_data,
    output logic              eof_seen,
    output logic              last_entry,
    output logic [DESC_W-1:0] wr_data
);
    logic [LEN_W-1:0]  len_q;
    logic              fcs_q;
    logic              mac_q;
    logic [DESC_W-1:0] desc_q;
    logic [ERR_W-1:0]  err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eof_seen <= 1'b0;
            len_q    <= '0;
            fcs_q    <= 1'b0;
            mac_q    <= 1'b0;
        end else if (eof_cap_en && rx_eof) begin
            eof_seen <= 1'b1;
            len_q    <= rx_len;
            fcs_q    <= rx_fcs_err;
            mac_q    <= rx_mac_err;
        end else if (eof_clr) begin
            eof_seen <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        desc_q <= '0;
        else if (cap_desc) desc_q <= rd_data;
    end

    always_comb begin
        err         = '0;
        err[E_FCS]  = fcs_q;
        err[E_MAC]  = mac_q;
        err[E_RUNT] = (len_q < min_len);
        err[E_OVER] = (len_q > max_len);
    end

    always_comb begin
        wr_data                     = desc_q;
        wr_data[OWN_BIT]            = 1'b0;
        wr_data[ERR_LSB +: ERR_W]   = err;
        wr_data[LEN_LSB +: LEN_W]   = len_q;
    end

    assign last_entry = desc_q[LAST_BIT];
endmodule

// File: rtl/rdr_evt.sv
module rdr_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_set,
    input  logic busy_clr,
    input  logic resume,
    input  logic stop_set,
    input  logic stop_clr,
    output logic busy_q,
    output logic halt_q,
    output logic stopd_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            halt_q  <= 1'b0;
            stopd_q <= 1'b0;
        end else begin
            if (busy_set)      busy_q <= 1'b1;
            else if (busy_clr) busy_q <= 1'b0;
            if (busy_set)      halt_q <= 1'b1;
            else if (resume)   halt_q <= 1'b0;
            if (stop_set)      stopd_q <= 1'b1;
            else if (stop_clr) stopd_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
    import rdr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_ring_base,
    input  logic [LEN_W-1:0]  cfg_min_len,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_fcs_err,
    input  logic              rx_mac_err,
    input  logic              rx_stop_req,
    input  logic              rx_resume,
    input  logic              evt_busy_clr,
    input  logic              evt_stop_clr,
    output logic              desc_rd_en,
    output logic [AW-1:0]     desc_addr,
    input  logic [DESC_W-1:0] desc_rd_data,
    output logic              desc_wr_en,
    output logic [DESC_W-1:0] desc_wr_data,
    output logic              evt_busy,
    output logic              evt_stop_done,
    output logic              rx_halted
);
    rdr_state_e state;
    logic advance, cap_desc, eof_cap_en, eof_clr;
    logic busy_set, stop_set, eof_seen, last_entry;

    rdr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .stop_req   (rx_stop_req),
        .halt_q     (rx_halted),
        .desc_owned (desc_rd_data[OWN_BIT]),
        .eof_seen   (eof_seen),
        .state      (state),
        .rd_en      (desc_rd_en),
        .wr_en      (desc_wr_en),
        .advance    (advance),
        .cap_desc   (cap_desc),
        .eof_cap_en (eof_cap_en),
        .eof_clr    (eof_clr),
        .busy_set   (busy_set),
        .stop_set   (stop_set)
    );

    rdr_ptr #(.AW(AW)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .base       (cfg_ring_base),
        .advance    (advance),
        .last_entry (last_entry),
        .addr       (desc_addr)
    );

    rdr_wb u_wb (
        .clk        (clk),
        .rst_n      (rst_n),
        .eof_cap_en (eof_cap_en),
        .eof_clr    (eof_clr),
        .cap_desc   (cap_desc),
        .rx_eof     (rx_eof),
        .rx_len     (rx_len),
        .rx_fcs_err (rx_fcs_err),
        .rx_mac_err (rx_mac_err),
        .min_len    (cfg_min_len),
        .max_len    (cfg_max_len),
        .rd_data    (desc_rd_data),
        .eof_seen   (eof_seen),
        .last_entry (last_entry),
        .wr_data    (desc_wr_data)
    );

    rdr_evt u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_set (busy_set),
        .busy_clr (evt_busy_clr),
        .resume   (rx_resume),
        .stop_set (stop_set),
        .stop_clr (evt_stop_clr),
        .busy_q   (evt_busy),
        .halt_q   (rx_halted),
        .stopd_q  (evt_stop_done)
    );
endmodule

// File: rtl/rdr_checker.sv
module rdr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        desc_rd_en,
    input logic        desc_wr_en,
    input logic [31:0] desc_wr_data,
    input logic        evt_busy,
    input logic        rx_halted,
    input logic        rx_resume
);
    a_r7_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        rx_halted |-> (!desc_rd_en && !desc_wr_en));

    a_r2_handover: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_en |-> !desc_wr_data[31]);

    a_r11_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_en |=> !desc_wr_en);

    a_r6_busy_halts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_busy) |-> rx_halted);

    a_r8_resume_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_halted && rx_resume) |=> !rx_halted);
endmodule

bind rx_desc_ring rdr_checker u_rdr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .desc_rd_en   (desc_rd_en),
    .desc_wr_en   (desc_wr_en),
    .desc_wr_data (desc_wr_data),
    .evt_busy     (evt_busy),
    .rx_halted    (rx_halted),
    .rx_resume    (rx_resume)
);

// File: tb/rx_desc_ring_bench.sv
module rx_desc_ring_bench;
    localparam int AW = 8;
    localparam logic [31:0] OWN  = 32'h8000_0000;
    localparam logic [31:0] LAST = 32'h2000_0000;
    localparam logic [AW-1:0] BASE = 8'd8;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] cfg_ring_base = BASE;
    logic [15:0] cfg_min_len = 16'd64, cfg_max_len = 16'd1518;
    logic rx_sof = 0, rx_eof = 0, rx_fcs_err = 0, rx_mac_err = 0;
    logic [15:0] rx_len = 0;
    logic rx_stop_req = 0, rx_resume = 0, evt_busy_clr = 0, evt_stop_clr = 0;
    logic desc_rd_en, desc_wr_en, evt_busy, evt_stop_done, rx_halted;
    logic [AW-1:0] desc_addr;
    logic [31:0] desc_rd_data = 0, desc_wr_data;

    logic [31:0] mem [0:(1<<AW)-1];
    logic sw_we = 0;
    logic [AW-1:0] sw_a = 0;
    logic [31:0] sw_d = 0;
    int rd_cnt = 0, wr_cnt = 0;
    int total = 0, bad = 0;
    int model_idx = 0;

    always #5 clk = ~clk;

    rx_desc_ring #(.AW(AW)) u_rx_desc_ring (.*);

    always @(posedge clk) begin
        if (sw_we) mem[sw_a] <= sw_d;
        if (desc_wr_en) begin mem[desc_addr] <= desc_wr_data; wr_cnt <= wr_cnt + 1; end
        if (desc_rd_en) begin desc_rd_data <= mem[desc_addr]; rd_cnt <= rd_cnt + 1; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic arm(input int i, input bit last);
        @(negedge clk);
        sw_we = 1; sw_a = BASE + AW'(i);
        sw_d = OWN | (last ? LAST : 32'h0) | (32'(i) << 24) | 32'h000F_FFFF;
        @(negedge clk);
        sw_we = 0;
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] old, input int len,
                                                input bit fcs, input bit mac);
        logic [3:0] e;
        e = {len > 1518, len < 64, mac, fcs};
        return (old & ~(OWN | 32'h000F_FFFF)) | (32'(e) << 16) | 32'(len);
    endfunction

    task automatic frame(input int len, input bit fcs, input bit mac, input int gap);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        rx_sof = 1;
        @(negedge clk);
        rx_sof = 0;
        repeat (gap) @(negedge clk);
        rx_eof = 1; rx_len = 16'(len); rx_fcs_err = fcs; rx_mac_err = mac;
        @(negedge clk);
        rx_eof = 0; rx_fcs_err = 0; rx_mac_err = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1;
        @(negedge clk); s = 0;
        @(negedge clk);
    endtask

    task automatic good_frame(input string req, input int len, input bit fcs,
                              input bit mac, input int gap);
        logic [31:0] old;
        old = mem[BASE + AW'(model_idx)];
        frame(len, fcs, mac, gap);
        chk(req, mem[BASE + AW'(model_idx)], expect_word(old, len, fcs, mac));
        chk({req, " R11 one write"}, 32'(wr_cnt), 1);
        model_idx = old[29] ? 0 : model_idx + 1;
        chk({req, " R5 next position"}, 32'(desc_addr), 32'(BASE + AW'(model_idx)));
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy", 32'(evt_busy), 0);
        chk("R1 stop_done", 32'(evt_stop_done), 0);
        chk("R1 halted", 32'(rx_halted), 0);
        chk("R1 strobes", {30'h0, desc_rd_en, desc_wr_en}, 0);
        chk("R1 addr", 32'(desc_addr), 32'(BASE));

        for (int i = 0; i < 4; i++) arm(i, i == 3);
        good_frame("R2 good 64", 64, 0, 0, 3);
        good_frame("R10 early eof / R4 fcs", 1518, 1, 0, 0);
        good_frame("R3 runt", 60, 0, 0, 2);
        good_frame("R3 oversize / R4 mac / R5 wrap", 1600, 0, 1, 4);

        arm(0, 0);
        good_frame("R5 after wrap", 200, 0, 0, 1);

        // R6: entry 1 still owned by software
        begin
            logic [31:0] keep;
            keep = mem[BASE + 1];
            frame(300, 0, 0, 2);
            chk("R6 busy", 32'(evt_busy), 1);
            chk("R6 halted", 32'(rx_halted), 1);
            chk("R6 no write", 32'(wr_cnt), 0);
            chk("R6 desc kept", mem[BASE + 1], keep);
            frame(400, 0, 0, 2);
            chk("R7 no access while halted", 32'(rd_cnt + wr_cnt), 0);
            chk("R7 desc kept", mem[BASE + 1], keep);
        end
        pulse(evt_busy_clr);
        chk("R8 busy cleared", 32'(evt_busy), 0);
        chk("R8 still halted", 32'(rx_halted), 1);
        pulse(rx_resume);
        chk("R8 resumed", 32'(rx_halted), 0);
        chk("R8 same position", 32'(desc_addr), 32'(BASE + 1));
        arm(1, 0);
        good_frame("R8 after resume", 128, 0, 0, 2);

        // R9: stop raised mid-frame
        arm(2, 0);
        begin
            logic [31:0] old;
            old = mem[BASE + 2];
            @(negedge clk); wr_cnt = 0; rx_sof = 1;
            @(negedge clk); rx_sof = 0; rx_stop_req = 1;
            @(negedge clk);
            rx_eof = 1; rx_len = 16'd90;
            @(negedge clk); rx_eof = 0;
            repeat (6) @(negedge clk);
            chk("R9 frame completed", mem[BASE + 2], expect_word(old, 90, 0, 0));
            chk("R9 stop_done", 32'(evt_stop_done), 1);
            model_idx = 3;
        end
        frame(100, 0, 0, 2);
        chk("R9 ignored while stopped", 32'(rd_cnt + wr_cnt), 0);
        pulse(evt_stop_clr);
        chk("R9 stop_done cleared", 32'(evt_stop_done), 0);
        @(negedge clk); rx_stop_req = 0;
        arm(3, 1);
        good_frame("R9 after release", 256, 0, 0, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule